// File: doc/BRIEF.md
# General-Purpose Port with Timer Frequency Output Sharing

An 8-bit bidirectional port sits on a simple register bus. Each line has an output latch bit and a direction bit. A direction bit of 1 makes the line an input, with its pad driver off. A direction bit of 0 makes the line a push-pull output that drives its latch bit. Pad inputs pass through a two-flop synchronizer before any logic uses them.

A data read returns a mixed view of the port. Input lines report the synchronized pad level and output lines report their latch. Single-bit set and clear operations are read-modify-write: the block takes that mixed view, changes one bit and writes the whole result back to the latch. So a bit op also copies the current pad levels of the input lines into their latch bits.

One line (bit 3 by default) can carry the divided timer frequency signal in place of its latch. When that option is on and the line is an output, latch bit 1 lets the timer signal through and latch bit 0 holds the pin low. In input mode the line behaves normally whether the option is on or off. Every input line can raise a wake-up request on a falling edge when wake-up is enabled.

Top module: `gpio_port_pfd`

## Requirements
- R1: After reset, every direction bit and every latch bit is 1. So `pad_oe` is 0x00, `pad_out` is 0xFF and reading address 1 returns 0xFF.
- R2: `pad_oe[i]` is 1 exactly when direction bit i is 0 (output). Direction is written at address 1.
- R3: A read at address 0 returns the synchronized pad level for bits whose direction bit is 1 and the latch bit for bits whose direction bit is 0.
- R4: The latch changes only on a write at address 0 or a valid bit op. Idle cycles and direction writes leave `pad_out` unchanged.
- R5: A write at address 2 with data k (k < 8) loads the latch with the address-0 read view, with bit k set. A k of 8 or more leaves the latch unchanged.
- R6: A write at address 3 with data k (k < 8) loads the latch with the address-0 read view, with bit k cleared.
- R7: With `pfd_opt`=1 and bit 3 an output, `pad_out[3]` follows `pfd_in` when latch bit 3 is 1 and is 0 when latch bit 3 is 0.
- R8: With `pfd_opt`=0, `pad_out[3]` is latch bit 3. `pfd_opt` never affects the other bits.
- R9: With bit 3 an input, `pad_oe[3]` is 0 and a read returns the pad level of bit 3, even when `pfd_opt`=1.
- R10: With `wake_en`=1, a falling edge on an input line raises `wake_req` for exactly one cycle, three clock edges after the pad change.
- R11: A falling edge on an output line, or any edge while `wake_en`=0, raises no `wake_req`.
- R12: A pad change shows up in an address-0 read two clock edges after it is applied, not one.
- R13: A read at address 1 returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken when `bus_sel` is 1 |
| bus_addr | input | 2 | 0 data, 1 direction, 2 bit set, 3 bit clear |
| bus_wdata | input | 8 | Write data or bit index |
| bus_rdata | output | 8 | Combinational read data |
| pfd_opt | input | 1 | Bit 3 carries the timer frequency signal |
| pfd_in | input | 1 | Divided timer frequency signal |
| wake_en | input | 1 | Wake-up enable |
| pad_in | input | 8 | Pad levels, asynchronous |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad driver enables, 1 = drive |
| wake_req | output | 1 | One-cycle wake-up pulse |

## Verification
Each result has a fixed delay:
- `pad_oe`, `pad_out` and the read data reflect a register write one edge after the write is presented.
- The mux outputs follow `pfd_opt` and `pfd_in` in the same cycle.
- A pad change reaches the read data after two edges.
- A pad change reaches `wake_req` after three edges.

The driver tags every expected item with its absolute due cycle, worked out from these counts. The monitor compares at the falling clock edge of exactly that cycle and flags any item that goes past due. For the synchronizer and wake pulse, the bench also checks the cycle before and the cycle after the due cycle, so a result that comes one cycle early or late fails.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    GP_REG_DATA = 2'd0,
    GP_REG_DIR  = 2'd1,
    GP_REG_BSET = 2'd2,
    GP_REG_BCLR = 2'd3
  } gp_reg_e;

  typedef enum logic [1:0] {
    GP_OP_NONE,
    GP_OP_LOAD,
    GP_OP_SET,
    GP_OP_CLR
  } gp_latch_op_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '1;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] pad_sync,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] bus_rdata
);

  // mixed view: pad for inputs, latch for outputs
  function automatic logic [WIDTH-1:0] port_view(
    input logic [WIDTH-1:0] dir,
    input logic [WIDTH-1:0] pad,
    input logic [WIDTH-1:0] lat
  );
    return (dir & pad) | (~dir & lat);
  endfunction

  // one-hot mask of a bit index; zero when out of range
  function automatic logic [WIDTH-1:0] index_mask(input logic [WIDTH-1:0] idx);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int k = 0; k < WIDTH; k++) m[k] = (idx == WIDTH'(k));
    return m;
  endfunction

  gp_latch_op_e     latch_op;
  logic             latch_we;
  logic             dir_we;
  logic [WIDTH-1:0] view;
  logic [WIDTH-1:0] bit_mask;
  logic [WIDTH-1:0] latch_nxt;
  gp_reg_e          reg_sel;

  assign reg_sel  = gp_reg_e'(bus_addr);
  assign view     = port_view(dir_q, pad_sync, latch_q);
  assign bit_mask = index_mask(bus_wdata);
  assign dir_we   = bus_sel && bus_wr && (reg_sel == GP_REG_DIR);

  always_comb begin
    latch_op = GP_OP_NONE;
    if (bus_sel && bus_wr) begin
      case (reg_sel)
        GP_REG_DATA: latch_op = GP_OP_LOAD;
        GP_REG_BSET: latch_op = (|bit_mask) ? GP_OP_SET : GP_OP_NONE;
        GP_REG_BCLR: latch_op = (|bit_mask) ? GP_OP_CLR : GP_OP_NONE;
        default:     latch_op = GP_OP_NONE;
      endcase
    end
  end

  always_comb begin
    case (latch_op)
      GP_OP_LOAD: latch_nxt = bus_wdata;
      GP_OP_SET:  latch_nxt = view | bit_mask;
      GP_OP_CLR:  latch_nxt = view & ~bit_mask;
      default:    latch_nxt = latch_q;
    endcase
  end

  assign latch_we = (latch_op != GP_OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '1;
    end else begin
      if (latch_we) latch_q <= latch_nxt;
      if (dir_we)   dir_q   <= bus_wdata;
    end
  end

  always_comb begin
    case (reg_sel)
      GP_REG_DATA: bus_rdata = view;
      GP_REG_DIR:  bus_rdata = dir_q;
      default:     bus_rdata = '0;
    endcase
  end

  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(latch_q));

  a_r5_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_op == GP_OP_SET) |=> ((latch_q & $past(bit_mask)) == $past(bit_mask)));

  a_r6_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_op == GP_OP_CLR) |=> ((latch_q & $past(bit_mask)) == '0));

  a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_we |=> $stable(dir_q));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int WIDTH   = 8,
  parameter int PFD_BIT = 3
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  input  logic             pfd_opt,
  input  logic             pfd_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_line
      assign pad_oe[i] = ~dir_q[i];
      if (i == PFD_BIT) begin : g_pfd
        // latch bit gates the timer signal when shared
        assign pad_out[i] = pfd_opt ? (latch_q[i] & pfd_in) : latch_q[i];
      end else begin : g_plain
        assign pad_out[i] = latch_q[i];
      end
    end
  endgenerate

  always_comb begin
    if (pfd_opt && !latch_q[PFD_BIT] && !dir_q[PFD_BIT])
      a_r7_pfd_gated_low: assert (pad_out[PFD_BIT] == 1'b0);
    if (dir_q[PFD_BIT])
      a_r9_pfd_input_undriven: assert (pad_oe[PFD_BIT] == 1'b0);
  end

endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pad_sync,
  input  logic             wake_en,
  output logic             wake_req
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] fall_lines;
  logic             fall_evt;

  assign fall_lines = prev_q & ~pad_sync & dir_q;
  assign fall_evt   = wake_en && (|fall_lines);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '1;
      wake_req <= 1'b0;
    end else begin
      prev_q   <= pad_sync;
      wake_req <= fall_evt;
    end
  end

  a_r11_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(wake_en));

  a_r11_wake_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(|dir_q));

  a_r10_wake_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(|(prev_q & ~pad_sync)));

endmodule

// File: rtl/gpio_port_pfd.sv
module gpio_port_pfd #(
  parameter int WIDTH       = 8,
  parameter int PFD_BIT     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             pfd_opt,
  input  logic             pfd_in,
  input  logic             wake_en,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             wake_req
);

  logic [WIDTH-1:0] pad_sync;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pad_in), .d_sync(pad_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_sync(pad_sync),
    .latch_q(latch_q), .dir_q(dir_q), .bus_rdata(bus_rdata)
  );

  gpio_pad_mux #(.WIDTH(WIDTH), .PFD_BIT(PFD_BIT)) u_mux (
    .dir_q(dir_q), .latch_q(latch_q), .pfd_opt(pfd_opt), .pfd_in(pfd_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_wake #(.WIDTH(WIDTH)) u_wake (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .pad_sync(pad_sync),
    .wake_en(wake_en), .wake_req(wake_req)
  );

  a_r2_oe_tracks_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd1) |=> (pad_oe == ~$past(bus_wdata)));

  a_r8_pfd_off_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfd_opt && $stable(pfd_opt) && $stable(latch_q)) |-> $stable(pad_out));

endmodule

// File: tb/tb_gpio_port_pfd.sv
module tb_gpio_port_pfd;

  typedef struct {
    int          due;
    int          kind;   // 0 rdata, 1 pad_out, 2 pad_oe, 3 wake_req
    logic [7:0]  exp;
    string       req;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 2'd1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pfd_opt = 0, pfd_in = 0, wake_en = 0;
  logic [7:0] pad_in = 8'hFF;
  logic [7:0] pad_out, pad_oe;
  logic       wake_req;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_port_pfd dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pfd_opt(pfd_opt), .pfd_in(pfd_in), .wake_en(wake_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .wake_req(wake_req)
  );

  function automatic logic [7:0] actual(input int kind);
    case (kind)
      0: return bus_rdata;
      1: return pad_out;
      2: return pad_oe;
      default: return {7'b0, wake_req};
    endcase
  endfunction

  // monitor: pops items due in this cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = q.size() - 1; k >= 0; k--) begin
        if (q[k].due == cyc) begin
          total++;
          if (actual(q[k].kind) !== q[k].exp) begin
            bad++;
            $display("FAIL %s kind=%0d cyc=%0d: actual=%h expected=%h",
                     q[k].req, q[k].kind, cyc, actual(q[k].kind), q[k].exp);
          end
          q.delete(k);
        end else if (q[k].due < cyc) begin
          total++; bad++;
          $display("FAIL %s missed: actual=none expected=%h", q[k].req, q[k].exp);
          q.delete(k);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_at(input int delay, input int kind, input logic [7:0] v, input string req);
    item_t it;
    it.due = cyc + delay; it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step();
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic set_pad(input logic [7:0] v);
    step();
    pad_in = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state, R13 direction readback
    expect_at(0, 2, 8'h00, "R1");
    expect_at(0, 1, 8'hFF, "R1");
    expect_at(0, 0, 8'hFF, "R1_R13");
    drain();

    // R2 direction, R13 readback
    wr(2'd1, 8'hF0);
    expect_at(0, 2, 8'h0F, "R2");
    expect_at(0, 0, 8'hF0, "R13");
    drain();

    // latch load and mixed read, R12 sync delay
    wr(2'd0, 8'hA5);
    expect_at(0, 1, 8'hA5, "R4");
    drain();
    set_pad(8'h3C);
    bus_addr = 2'd0;
    expect_at(1, 0, 8'hF5, "R12");
    expect_at(2, 0, 8'h35, "R3_R12");
    drain();

    // R4 hold across direction write and idle
    wr(2'd1, 8'hF0);
    expect_at(0, 1, 8'hA5, "R4");
    expect_at(5, 1, 8'hA5, "R4");
    drain();

    // R5 set and R6 clear via read-modify-write
    wr(2'd2, 8'd1);
    expect_at(0, 1, 8'h37, "R5");
    drain();
    wr(2'd3, 8'd2);
    expect_at(0, 1, 8'h33, "R6");
    drain();
    wr(2'd2, 8'd9);
    expect_at(0, 1, 8'h33, "R5");
    drain();

    // R7 gated timer signal, R8 option off
    step(); pfd_opt = 1; pfd_in = 1;
    expect_at(0, 1, 8'h33, "R7");
    drain();
    wr(2'd0, 8'h3B);
    expect_at(0, 1, 8'h3B, "R7");
    drain();
    step(); pfd_in = 0;
    expect_at(0, 1, 8'h33, "R7");
    drain();
    step(); pfd_opt = 0;
    expect_at(0, 1, 8'h3B, "R8");
    drain();
    step(); pfd_opt = 1;
    expect_at(0, 1, 8'h33, "R8");
    drain();

    // R9 shared bit as input
    wr(2'd1, 8'hF8);
    bus_addr = 2'd0;
    expect_at(0, 2, 8'h07, "R9");
    drain();
    set_pad(8'h08);
    expect_at(2, 0, 8'h0B, "R9");
    drain();

    // R10 wake pulse on input falling edge
    step(); wake_en = 1;
    set_pad(8'hFF);
    expect_at(3, 3, 8'h00, "R10");
    drain();
    set_pad(8'h7F);
    expect_at(2, 3, 8'h00, "R10");
    expect_at(3, 3, 8'h01, "R10");
    expect_at(4, 3, 8'h00, "R10");
    drain();
    set_pad(8'hFF);
    drain(); step(); step();

    // R11 output line and disabled wake
    set_pad(8'hFE);
    expect_at(3, 3, 8'h00, "R11");
    expect_at(4, 3, 8'h00, "R11");
    drain();
    set_pad(8'hFF);
    step(); step(); step();
    wake_en = 0;
    set_pad(8'hBF);
    expect_at(3, 3, 8'h00, "R11");
    expect_at(4, 3, 8'h00, "R11");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule